// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is the station-management master of a 10/100 Ethernet MAC. Software loads a 16-bit data register, then writes a 16-bit control word that names the PHY, the PHY register and the direction. The write to the control word launches one Clause 22 management frame on the MDC clock and MDIO data pins.

While the frame runs, a finish flag in the control register reads 0. Software polls the flag before it issues the next command. For a read, the master releases MDIO from the turnaround onward and shifts the PHY's 16 data bits into the data register. If no PHY answers, the line is pulled high and the register reads 0xFFFF.

MDC is produced only while a frame runs. It is the system clock divided by `2*CLK_DIV`. MDIO changes after MDC falls and is sampled when MDC rises.

Top module: `mdio_master`

## Requirements
- R1: The control word (bus_addr=1) holds the PHY register number in bits 4:0, the PHY address in bits 12:8 and a write flag in bit 13 (1 = write, 0 = read). Bits 7:5 and 15:14 of a written word are dropped. Reading the control register returns {finish, 0, write flag, PHY address, 000, register number}.
- R2: Each frame is 64 MDIO bits, sent MSB first, in this order: 32 ones, start 01, opcode (01 for a write, 10 for a read), the 5-bit PHY address, the 5-bit register number, a 2-bit turnaround and 16 data bits. For a write the master drives the turnaround as 10 and then the data register.
- R3: An accepted write to the control word starts a frame. Bit 15 of the control register (finish) reads 0 from the next cycle. It returns to 1 exactly 128*CLK_DIV clock cycles after the write, with exactly 64 MDC rising edges in between.
- R4: Writing the data register (bus_addr=0) while idle stores the value, and a write frame sends that value. After a write frame the data register still holds it.
- R5: During a read frame the master drives MDIO for bits 0 to 45 and releases it (mdio_oe=0) from the first turnaround bit to the end. It samples the 16 data bits on MDC rising edges and, at the end of the frame, places them in the data register.
- R6: A read from an address where no PHY answers returns 0xFFFF in the data register.
- R7: MDC is low whenever no frame runs and after reset. It toggles every CLK_DIV clock cycles during a frame, and the master changes MDIO only in the cycle where MDC falls.
- R8: Writes to either register while a frame is in progress are ignored. The running frame, the control fields and the data register are left unchanged.
- R9: After reset the data register reads 0x0000, the control register reads 0x8000, and mdc and mdio_oe are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 = data, 1 = control |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Read data of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO line value as seen at the pin |

## Verification
A wrong bit counter or divider shows up at the ports in two ways. The finish flag returns at the wrong cycle, or the bench's line monitor counts other than 64 MDC rising edges. Both are visible at the end of the first frame.

A fault in the shift register or in field packing corrupts the 64-bit pattern that the bench captures on MDC rising edges, starting at the first wrong bit. A fault in the read-release or sampling logic shows up in two places: in the output-enable trace the bench captures over the same frame, and in the data register once finish returns. A busy-lock fault shows as a changed control readback or data value right after the frame into which the bench injected a write.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int CLK_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic        bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(CLK_DIV - 1);
  localparam logic [5:0] TA_BIT   = 6'd46;
  localparam logic [5:0] DATA_BIT = 6'd48;
  localparam logic [5:0] LAST_BIT = 6'd63;

  logic [CW-1:0] cnt;
  logic          busy, mdc_q, wr_q;
  logic [5:0]    bitcnt;
  logic [63:0]   tx;
  logic [15:0]   rx, data_q;
  logic [4:0]    phy_q, reg_q;

  wire tick    = busy && (cnt == CNT_TOP);
  wire fall    = tick && mdc_q;
  wire rise    = tick && !mdc_q;
  wire ctl_we  = bus_we && bus_addr && !busy;
  wire data_we = bus_we && !bus_addr && !busy;
  wire cmd_wr  = bus_wdata[13];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      busy   <= 1'b0;
      mdc_q  <= 1'b0;
      wr_q   <= 1'b0;
      bitcnt <= '0;
      tx     <= '0;
      rx     <= '0;
      data_q <= '0;
      phy_q  <= '0;
      reg_q  <= '0;
    end else begin
      if (data_we) data_q <= bus_wdata;
      if (ctl_we) begin
        wr_q   <= cmd_wr;
        phy_q  <= bus_wdata[12:8];
        reg_q  <= bus_wdata[4:0];
        busy   <= 1'b1;
        cnt    <= '0;
        mdc_q  <= 1'b0;
        bitcnt <= '0;
        tx     <= {32'hFFFF_FFFF, 2'b01, cmd_wr ? 2'b01 : 2'b10,
                   bus_wdata[12:8], bus_wdata[4:0], 2'b10,
                   cmd_wr ? data_q : 16'hFFFF};
      end else if (busy) begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (tick) mdc_q <= ~mdc_q;
        if (rise && !wr_q && bitcnt >= DATA_BIT) rx <= {rx[14:0], mdio_i};
        if (fall) begin
          if (bitcnt == LAST_BIT) begin
            busy <= 1'b0;
            if (!wr_q) data_q <= rx;
          end else begin
            bitcnt <= bitcnt + 1'b1;
            tx     <= {tx[62:0], 1'b1};
          end
        end
      end
    end
  end

  assign mdc       = mdc_q;
  assign mdio_o    = tx[63];
  assign mdio_oe   = busy && (wr_q || bitcnt < TA_BIT);
  assign bus_rdata = bus_addr ? {~busy, 1'b0, wr_q, phy_q, 3'b000, reg_q} : data_q;

  // R7
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc_q);

  // R7
  mdio_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc_q));

  // R8
  ctl_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable({wr_q, phy_q, reg_q}));

  // R8
  data_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_q) |=> $stable(data_q));

  // R3
  frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (bitcnt == 6'd0 && !mdc_q && mdio_oe));

  // R5
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_q && $past(!mdio_oe) && $past(busy)) |-> !mdio_oe);
endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2;
  localparam logic [4:0] PHY_ADR = 5'd5;

  logic clk = 0, rst_n = 0, bus_we = 0, bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic mdc, mdio_o, mdio_oe;
  logic phy_drv = 0, phy_bit = 1;
  wire  mdio_line = mdio_oe ? mdio_o : (phy_drv ? phy_bit : 1'b1);

  int tests = 0, fails = 0;
  bit finished = 0;

  mdio_master #(.CLK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] mem [32];
  logic [63:0] cap, oecap;
  int bcnt = 0;
  logic rd_act = 0;
  logic [15:0] rd_val = 0;

  always @(posedge mdc) begin
    cap   = {cap[62:0], mdio_line};
    oecap = {oecap[62:0], mdio_oe};
    bcnt++;
    if (bcnt == 46) begin
      rd_act = (cap[11:10] == 2'b10) && (cap[9:5] == PHY_ADR);
      rd_val = mem[cap[4:0]];
    end
    if (bcnt == 64 && cap[29:28] == 2'b01 && cap[27:23] == PHY_ADR)
      mem[cap[22:18]] = cap[15:0];
  end

  always @(negedge mdc) begin
    if (rd_act && bcnt >= 47 && bcnt <= 63) begin
      phy_drv = 1;
      phy_bit = (bcnt == 47) ? 1'b0 : rd_val[63 - bcnt];
    end else phy_drv = 0;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [15:0] v);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_we = 0;
  endtask

  function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] phy,
      input logic [4:0] rg, input logic [15:0] dat, input logic present);
    return {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, phy, rg,
            wr ? 2'b10 : {1'b1, ~present}, dat};
  endfunction

  task automatic run_cmd(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
      input logic [15:0] dat, input bit inject);
    logic present, fin;
    logic [15:0] rdv, ctl, exp_d;
    logic [4:0] junk;
    int n;
    present = (phy == PHY_ADR);
    rdv = present ? mem[rg] : 16'hFFFF;
    junk = 5'($urandom);
    ctl = {junk[1:0], wr, phy, junk[4:2], rg};
    if (wr) bus_write(0, dat);
    bcnt = 0; rd_act = 0;
    bus_write(1, ctl);
    n = 1;
    #1;
    // R3 finish low right after launch
    chk(bus_rdata[15] == 1'b0, "R3 finish low while busy", 64'(bus_rdata[15]), 64'd0);
    forever begin
      @(negedge clk);
      n++;
      if (n == 21) begin bus_we = 0; bus_addr = 1; end
      #1;
      fin = bus_rdata[15];
      if (n == 20 && inject) begin
        bus_we = 1; bus_addr = 1'($urandom); bus_wdata = 16'($urandom);
      end
      if (fin) break;
    end
    // R3 frame length
    chk(n == 128*DIV + 1, "R3 frame cycles", 64'(n), 64'(128*DIV + 1));
    chk(bcnt == 64, "R3 mdc rising edges", 64'(bcnt), 64'd64);
    // R2 frame content
    chk(cap == exp_frame(wr, phy, rg, wr ? dat : rdv, present), wr ? "R2 write frame" : "R2 read frame",
        cap, exp_frame(wr, phy, rg, wr ? dat : rdv, present));
    // R5 release pattern
    chk(oecap == (wr ? 64'hFFFF_FFFF_FFFF_FFFF : {{46{1'b1}}, {18{1'b0}}}), "R5 output enable trace",
        oecap, wr ? 64'hFFFF_FFFF_FFFF_FFFF : {{46{1'b1}}, {18{1'b0}}});
    // R7 idle low after frame
    chk(mdc == 1'b0, "R7 mdc idle low", 64'(mdc), 64'd0);
    // R1 / R8 control readback
    bus_addr = 1; #1;
    chk(bus_rdata == {1'b1, 1'b0, wr, phy, 3'b000, rg}, inject ? "R8 R1 control readback" : "R1 control readback",
        64'(bus_rdata), 64'({1'b1, 1'b0, wr, phy, 3'b000, rg}));
    // R4 R5 R6 R8 data register
    bus_addr = 0; #1;
    exp_d = wr ? dat : rdv;
    chk(bus_rdata == exp_d, wr ? "R4 R8 data kept" : (present ? "R5 read data" : "R6 absent phy"),
        64'(bus_rdata), 64'(exp_d));
  endtask

  initial begin
    void'($urandom(1234));
    for (int i = 0; i < 32; i++) mem[i] = 16'(i * 16'h0931) ^ 16'h5A00;
    repeat (3) @(negedge clk);
    // R9 reset state
    bus_addr = 0; #1;
    chk(bus_rdata == 16'h0000, "R9 data reset", 64'(bus_rdata), 64'h0);
    bus_addr = 1; #1;
    chk(bus_rdata == 16'h8000, "R9 control reset", 64'(bus_rdata), 64'h8000);
    chk(mdc == 0 && mdio_oe == 0, "R9 R7 pins reset", 64'({mdc, mdio_oe}), 64'h0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run_cmd(1, PHY_ADR, 5'd3, 16'hA5C3, 0);
    run_cmd(0, PHY_ADR, 5'd3, 16'h0, 0);
    run_cmd(0, 5'd0, 5'd1, 16'h0, 0);
    run_cmd(0, PHY_ADR, 5'd31, 16'h0, 1);
    run_cmd(1, PHY_ADR, 5'd0, 16'h0000, 1);
    run_cmd(0, PHY_ADR, 5'd0, 16'h0, 0);
    run_cmd(1, 5'd31, 5'd31, 16'hFFFF, 1);
    for (int k = 0; k < 24; k++) begin
      logic [4:0] p;
      p = ($urandom % 2) ? PHY_ADR : 5'($urandom);
      run_cmd(1'($urandom), p, 5'($urandom), 16'($urandom), bit'($urandom));
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule